// File: doc/BRIEF.md
# Microsecond Timebase with Alarm

This block turns a reference clock, whose frequency is a whole number of MHz given by a parameter, into a free-running microsecond count. A power-of-two prescaler divides the reference clock. Its ratio is picked at elaboration so that the divided rate is still a whole number of ticks per microsecond. A tick counter of parameterised width (16 bits by default) runs at that rate and wraps at a top value chosen so that one wrap spans a whole number of microseconds. A wrap counter extends the tick counter, and the microsecond value is derived from the two each cycle.

A single absolute-time alarm sits on top of the timebase. Software writes a target microsecond value with a strobe. The block converts the remaining distance into two parts: a number of full tick-counter wraps to let pass, and a compare position within the tick range. It then raises a sticky interrupt once the compare position has been met with no wraps left to skip. A target that lies too close or already behind makes the alarm fire a few ticks later. The interrupt is released by a clear pulse or by dropping the enable level.

Top module: `ustb_timebase`

## Requirements
- R1: The prescale exponent E is found by halving the reference MHz value while it is even, at most 10 times. The tick counter advances once every 2^E reference clocks, and ticks-per-microsecond (TPU) is the MHz value shifted right by E. For example, 12 MHz gives E=2 and TPU=3.
- R2: Microseconds per wrap is UPW = 2^TICK_W / TPU (integer division), and TOP = UPW*TPU - 1. The tick counter steps from TOP to 0.
- R3: The wrap counter increments on every tick-counter wrap. It returns to 0 instead of reaching TPU << TICK_W.
- R4: `us_o` equals tick/TPU + wraps*UPW (32-bit), delayed by one clock. The tick and wrap parts always come from the same cycle, so the output never moves backward except when it rolls over to 0.
- R5: After reset, `us_o` and `irq_o` are 0, both counters are 0 and the alarm is disarmed.
- R6: On arming, delta = target - current microseconds (mod 2^32). If delta < 50/MHz (integer division) or delta >= 0xFFFFFF00, the skip count is 0 and the compare position is tick+3, or 3 when tick+3 exceeds TOP.
- R7: Otherwise P = delta*TPU. The skip count is P >> TICK_W and the offset is the low TICK_W bits. If offset >= TOP, TOP is subtracted from the offset and the skip count is incremented. The compare position is tick+offset, reduced by TOP if that sum is >= TOP.
- R8: A match happens when the tick counter steps onto the compare position. On a match with a nonzero skip count, the count decrements and no interrupt is raised. On a match with a zero skip count, `irq_o` is set and the alarm disarms.
- R9: An arm strobe while enabled discards any previous alarm state and drops `irq_o` in the next cycle.
- R10: `irq_o` stays at 1 until a clear pulse. A clear in the same cycle as a firing match leaves it at 1.
- R11: While `alarm_en_i` is 0, the alarm is disarmed, `irq_o` is 0 and arm strobes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| us_o | output | 32 | Microsecond count |
| alarm_en_i | input | 1 | Alarm enable level |
| alarm_arm_i | input | 1 | Strobe: load and arm alarm target |
| alarm_time_i | input | 32 | Absolute alarm target in microseconds |
| alarm_clr_i | input | 1 | Pulse: clear the interrupt flag |
| irq_o | output | 1 | Sticky alarm interrupt |

## Verification
The bench runs with a small tick width (4 bits) at 12 MHz, so the whole wrap-counter cycle of 240 microseconds is covered. A continuous sweep there tells a correct count apart from an off-by-one top value, wrong prescaling or a late wrap-counter rollover. Alarm distances are chosen from a table to separate the passed-target cases (tiny and negative deltas), offsets just under, at and above TOP, single- and multi-wrap skips, and long waits. Each is checked against the exact clock in which the interrupt must appear, so an early or late fire, or a wrong skip count, shows up. Directed cases pit clear against a firing match, rearming against a pending flag, and disabled against armed alarms.

// File: rtl/ustb_pkg.sv
package ustb_pkg;

  localparam int US_W = 32;

  // Number of halvings of the MHz value while it stays even, capped at 10.
  function automatic int presc_exp(input int mhz);
    int v;
    int e;
    bit go;
    v  = mhz;
    e  = 0;
    go = 1'b1;
    for (int i = 0; i < 10; i++) begin
      if (go && v > 0 && (v % 2) == 0) begin
        v = v / 2;
        e = e + 1;
      end else begin
        go = 1'b0;
      end
    end
    return e;
  endfunction

  function automatic int ticks_per_us(input int mhz);
    return mhz >> presc_exp(mhz);
  endfunction

endpackage

// File: rtl/ustb_tick_core.sv
module ustb_tick_core #(
  parameter int EXP     = 4,
  parameter int TICK_W  = 16,
  parameter int TOP     = 65534,
  parameter int OVF_LIM = 196608,
  parameter int OVF_W   = 18
) (
  input  logic              clk,
  input  logic              rst,
  output logic              step_o,
  output logic [TICK_W-1:0] tick_o,
  output logic [TICK_W-1:0] tick_nxt_o,
  output logic [OVF_W-1:0]  ovf_o
);

  localparam logic [TICK_W-1:0] TOP_T  = TICK_W'(TOP);
  localparam logic [OVF_W-1:0]  OVF_MX = OVF_W'(OVF_LIM - 1);

  logic              step;
  logic              wrap;
  logic [TICK_W-1:0] tick_q;
  logic [OVF_W-1:0]  ovf_q;

  generate
    if (EXP == 0) begin : g_nodiv
      assign step = 1'b1;
    end else begin : g_div
      logic [EXP-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + EXP'(1);
      end
      assign step = &pre_q;
    end
  endgenerate

  assign wrap       = step && (tick_q == TOP_T);
  assign tick_nxt_o = (tick_q == TOP_T) ? '0 : tick_q + TICK_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tick_q <= '0;
      ovf_q  <= '0;
    end else begin
      if (step) tick_q <= tick_nxt_o;
      if (wrap) ovf_q  <= (ovf_q == OVF_MX) ? '0 : ovf_q + OVF_W'(1);
    end
  end

  assign step_o = step;
  assign tick_o = tick_q;
  assign ovf_o  = ovf_q;

  // R2: tick never exceeds top
  p_tick_range_r2: assert property (@(posedge clk) disable iff (rst)
    tick_q <= TOP_T);

  // R2: a step at top lands on zero
  p_tick_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (step && tick_q == TOP_T) |=> (tick_q == '0));

  // R3: the wrap counter stays below its limit
  p_ovf_range_r3: assert property (@(posedge clk) disable iff (rst)
    ovf_q <= OVF_MX);

  // R3: the wrap counter moves only when the tick counter wraps
  p_ovf_only_on_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    !(step && tick_q == TOP_T) |=> $stable(ovf_q));

endmodule

// File: rtl/ustb_us_conv.sv
module ustb_us_conv #(
  parameter int TICK_W = 16,
  parameter int OVF_W  = 18,
  parameter int TPU    = 3,
  parameter int UPW    = 21845
) (
  input  logic [TICK_W-1:0]        tick_i,
  input  logic [OVF_W-1:0]         ovf_i,
  output logic [ustb_pkg::US_W-1:0] now_o
);

  localparam int W = ustb_pkg::US_W;

  logic [W-1:0] frac_us;
  logic [W-1:0] whole_us;

  assign frac_us  = W'(tick_i) / W'(TPU);
  assign whole_us = W'(ovf_i) * W'(UPW);
  assign now_o    = whole_us + frac_us;

endmodule

// File: rtl/ustb_alarm.sv
module ustb_alarm #(
  parameter int TICK_W   = 16,
  parameter int TPU      = 3,
  parameter int TOP      = 65534,
  parameter int PASS_MIN = 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      en_i,
  input  logic                      arm_i,
  input  logic [ustb_pkg::US_W-1:0] target_i,
  input  logic                      clr_i,
  input  logic [ustb_pkg::US_W-1:0] now_i,
  input  logic                      step_i,
  input  logic [TICK_W-1:0]         tick_i,
  input  logic [TICK_W-1:0]         tick_nxt_i,
  output logic                      irq_o
);

  localparam int W      = ustb_pkg::US_W;
  localparam int PROD_W = W + $clog2(TPU + 1);
  localparam int SKIP_W = PROD_W - TICK_W + 1;
  localparam logic [TICK_W-1:0] TOP_T = TICK_W'(TOP);
  localparam logic [TICK_W:0]   TOP_X = {1'b0, TOP_T};
  localparam logic [W-1:0]      LATE  = 32'hFFFF_FF00;

  logic [W-1:0]      delta;
  logic              passed;
  logic [PROD_W-1:0] prod;
  logic [SKIP_W-1:0] skip_raw;
  logic [TICK_W-1:0] off_raw;
  logic [SKIP_W-1:0] skip_new;
  logic [TICK_W-1:0] off_adj;
  logic [TICK_W:0]   pos_sum;
  logic [TICK_W:0]   near_sum;
  logic [TICK_W-1:0] cmp_new;
  logic              hit;

  logic              armed_q;
  logic [SKIP_W-1:0] skip_q;
  logic [TICK_W-1:0] cmp_q;
  logic              irq_q;

  // Arm-time split of the distance into wraps to skip and a compare position.
  always_comb begin
    delta    = target_i - now_i;
    passed   = (delta < W'(PASS_MIN)) || (delta >= LATE);
    prod     = PROD_W'(delta) * PROD_W'(TPU);
    skip_raw = SKIP_W'(prod >> TICK_W);
    off_raw  = prod[TICK_W-1:0];
    if (off_raw >= TOP_T) begin
      off_adj  = off_raw - TOP_T;
      skip_new = skip_raw + SKIP_W'(1);
    end else begin
      off_adj  = off_raw;
      skip_new = skip_raw;
    end
    pos_sum  = {1'b0, tick_i} + {1'b0, off_adj};
    near_sum = {1'b0, tick_i} + (TICK_W + 1)'(3);
    if (passed) begin
      cmp_new  = (near_sum > TOP_X) ? TICK_W'(3) : near_sum[TICK_W-1:0];
      skip_new = '0;
    end else if (pos_sum >= TOP_X) begin
      cmp_new  = TICK_W'(pos_sum - TOP_X);
    end else begin
      cmp_new  = pos_sum[TICK_W-1:0];
    end
  end

  assign hit = armed_q && step_i && (tick_nxt_i == cmp_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      skip_q  <= '0;
      cmp_q   <= '0;
      irq_q   <= 1'b0;
    end else if (!en_i) begin
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      skip_q  <= skip_new;
      cmp_q   <= cmp_new;
      irq_q   <= 1'b0;
    end else if (hit) begin
      if (skip_q != '0) begin
        skip_q <= skip_q - SKIP_W'(1);
      end else begin
        armed_q <= 1'b0;
        irq_q   <= 1'b1;
      end
    end else if (clr_i) begin
      irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;

  // R11: disabled alarm keeps the interrupt low
  p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !irq_q);

  // R9: arming drops the interrupt
  p_arm_drops_irq_r9: assert property (@(posedge clk) disable iff (rst)
    (en_i && arm_i) |=> !irq_q);

  // R10: the flag holds without clear, disable or rearm
  p_irq_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_q && en_i && !arm_i && !clr_i) |=> irq_q);

  // R8: the interrupt only rises once no wraps remain
  p_fire_needs_zero_skip_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> $past(skip_q == '0 && armed_q));

  // R7: a stored compare position is always reachable
  p_cmp_in_range_r7: assert property (@(posedge clk) disable iff (rst)
    armed_q |-> (cmp_q <= TOP_T));

endmodule

// File: rtl/ustb_timebase.sv
module ustb_timebase #(
  parameter int REF_MHZ = 48,
  parameter int TICK_W  = 16
) (
  input  logic        clk,
  input  logic        rst,
  output logic [31:0] us_o,
  input  logic        alarm_en_i,
  input  logic        alarm_arm_i,
  input  logic [31:0] alarm_time_i,
  input  logic        alarm_clr_i,
  output logic        irq_o
);

  localparam int EXP      = ustb_pkg::presc_exp(REF_MHZ);
  localparam int TPU      = ustb_pkg::ticks_per_us(REF_MHZ);
  localparam int UPW      = (2 ** TICK_W) / TPU;
  localparam int TOP      = UPW * TPU - 1;
  localparam int OVF_LIM  = TPU << TICK_W;
  localparam int OVF_W    = $clog2(OVF_LIM);
  localparam int PASS_MIN = 50 / REF_MHZ;

  logic              step;
  logic [TICK_W-1:0] tick;
  logic [TICK_W-1:0] tick_nxt;
  logic [OVF_W-1:0]  ovf;
  logic [31:0]       now_us;
  logic [31:0]       us_q;
  logic              seen_q;

  ustb_tick_core #(
    .EXP(EXP), .TICK_W(TICK_W), .TOP(TOP), .OVF_LIM(OVF_LIM), .OVF_W(OVF_W)
  ) u_core (
    .clk(clk), .rst(rst), .step_o(step), .tick_o(tick),
    .tick_nxt_o(tick_nxt), .ovf_o(ovf)
  );

  ustb_us_conv #(
    .TICK_W(TICK_W), .OVF_W(OVF_W), .TPU(TPU), .UPW(UPW)
  ) u_conv (
    .tick_i(tick), .ovf_i(ovf), .now_o(now_us)
  );

  ustb_alarm #(
    .TICK_W(TICK_W), .TPU(TPU), .TOP(TOP), .PASS_MIN(PASS_MIN)
  ) u_alarm (
    .clk(clk), .rst(rst), .en_i(alarm_en_i), .arm_i(alarm_arm_i),
    .target_i(alarm_time_i), .clr_i(alarm_clr_i), .now_i(now_us),
    .step_i(step), .tick_i(tick), .tick_nxt_i(tick_nxt), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      us_q   <= '0;
      seen_q <= 1'b0;
    end else begin
      us_q   <= now_us;
      seen_q <= 1'b1;
    end
  end

  assign us_o = us_q;

  // R4: the output only moves forward, or rolls over to zero
  p_us_forward_r4: assert property (@(posedge clk) disable iff (rst)
    seen_q |-> (us_q >= $past(us_q) || us_q == '0));

  // R5: reset leaves the count at zero
  p_reset_zero_r5: assert property (@(posedge clk)
    $past(rst) |-> (us_q == '0));

endmodule

// File: tb/test_ustb_timebase.sv
module test_ustb_timebase;

  // Bench configuration: 12 MHz -> E=2, TPU=3, UPW=16/3=5, TOP=14,
  // period 15 ticks, wrap-count limit 3<<4=48, passed threshold 50/12=4.
  localparam int DIV  = 4;
  localparam int TPU  = 3;
  localparam int UPW  = 5;
  localparam int TOP  = 14;
  localparam int PER  = 15;
  localparam int LIM  = 48;
  localparam int PMIN = 4;

  localparam int NV = 10;
  // Vector: {delta in us, clear pulse in the firing cycle}
  localparam logic [32:0] VEC [NV] = '{
    {32'd2,          1'b0},   // passed: below threshold (R6)
    {32'hFFFF_FFF0,  1'b0},   // passed: behind now (R6)
    {32'd4,          1'b1},   // offset 12 (R7), clear vs fire (R10)
    {32'd5,          1'b0},   // offset 15 >= TOP -> 1, skip 1 (R7)
    {32'd6,          1'b0},   // skip 1 offset 2 (R8)
    {32'd3,          1'b0},   // passed: just below threshold (R6)
    {32'd33,         1'b1},   // skip 6 (R8, R10)
    {32'd100,        1'b0},   // skip 18 (R8)
    {32'd250,        1'b0},   // long wait (R8)
    {32'd1000,       1'b0}    // very long wait (R8)
  };

  logic        clk = 1'b0;
  logic        rst;
  logic [31:0] us_o;
  logic        alarm_en_i;
  logic        alarm_arm_i;
  logic [31:0] alarm_time_i;
  logic        alarm_clr_i;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  longint ncnt;
  bit done = 1'b0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) ncnt <= 0;
    else     ncnt <= ncnt + 1;
  end

  ustb_timebase #(.REF_MHZ(12), .TICK_W(4)) i_ustb_timebase (
    .clk(clk), .rst(rst), .us_o(us_o), .alarm_en_i(alarm_en_i),
    .alarm_arm_i(alarm_arm_i), .alarm_time_i(alarm_time_i),
    .alarm_clr_i(alarm_clr_i), .irq_o(irq_o)
  );

  function automatic logic [31:0] us_at(longint t);
    longint tk = t % PER;
    longint ov = (t / PER) % LIM;
    return 32'(tk / TPU + ov * UPW);
  endfunction

  // Clock edge at which the interrupt must appear, for arming in the cycle
  // whose tick state is absolute tick count t0.
  function automatic longint fire_edge(longint t0, logic [31:0] delta);
    longint tick0 = t0 % PER;
    longint cmp, skip, prod, off, s, d0;
    if (delta < PMIN || delta >= 32'hFFFF_FF00) begin
      cmp  = (tick0 + 3 > TOP) ? 3 : tick0 + 3;
      skip = 0;
    end else begin
      prod = longint'(delta) * TPU;
      skip = prod >> 4;
      off  = prod & 15;
      if (off >= TOP) begin
        off  = off - TOP;
        skip = skip + 1;
      end
      s = tick0 + off;
      if (s >= TOP) s = s - TOP;
      cmp = s;
    end
    d0 = (cmp - tick0 + PER) % PER;
    if (d0 == 0) d0 = PER;
    return DIV * (t0 + d0 + skip * PER);
  endfunction

  task automatic check(input bit ok, input string req, input longint act,
                       input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (edge %0d)", req, act, exp, ncnt);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // Arms at an edge that carries no tick step; returns the expected fire edge.
  task automatic arm_at(input logic [31:0] delta, output longint nf);
    longint t0;
    @(negedge clk);
    while (ncnt % DIV != 0) @(negedge clk);
    t0 = ncnt / DIV;
    alarm_time_i = us_at(t0) + delta;
    alarm_arm_i  = 1'b1;
    nf = fire_edge(t0, delta);
    @(negedge clk);
    alarm_arm_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    longint nf;
    bit early;
    rst = 1'b1;
    alarm_en_i = 1'b1;
    alarm_arm_i = 1'b0;
    alarm_time_i = '0;
    alarm_clr_i = 1'b0;
    repeat (3) @(negedge clk);
    check(us_o == 0, "R5 us in reset", us_o, 0);
    check(irq_o == 0, "R5 irq in reset", irq_o, 0);
    rst = 1'b0;

    // R1/R2/R3/R4: continuous sweep across a full wrap-count rollover
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      check(us_o == us_at((ncnt - 1) / DIV), "R1/R2/R4 us_o", us_o,
            us_at((ncnt - 1) / DIV));
      if (ncnt == 2880) check(us_o == 239, "R3 last us before rollover", us_o, 239);
      if (ncnt == 2881) check(us_o == 0, "R3 rollover to zero", us_o, 0);
      check(irq_o == 0, "R5 no alarm after reset", irq_o, 0);
    end

    // Table walk: distance, expected firing edge, optional clear collision
    for (int v = 0; v < NV; v++) begin
      arm_at(VEC[v][32:1], nf);
      early = 1'b0;
      while (ncnt < nf - 1) begin
        if (irq_o) early = 1'b1;
        @(negedge clk);
      end
      check(!early && irq_o == 0, "R6/R7/R8 no early fire", irq_o, 0);
      if (VEC[v][0]) alarm_clr_i = 1'b1;
      @(negedge clk);
      alarm_clr_i = 1'b0;
      check(irq_o == 1, VEC[v][0] ? "R10 clear vs fire keeps flag"
                                  : "R6/R7/R8 fires on time", irq_o, 1);
      repeat (20) @(negedge clk);
      check(irq_o == 1, "R10 flag sticky", irq_o, 1);
      alarm_clr_i = 1'b1;
      @(negedge clk);
      alarm_clr_i = 1'b0;
      check(irq_o == 0, "R10 clear drops flag", irq_o, 0);
      // R8: one-shot, no refire a period later
      repeat (2 * PER * DIV) @(negedge clk);
      check(irq_o == 0, "R8 disarmed after fire", irq_o, 0);
    end

    // R9: rearming drops a pending flag
    arm_at(32'd10, nf);
    while (ncnt < nf) @(negedge clk);
    check(irq_o == 1, "R9 setup fire", irq_o, 1);
    arm_at(32'd200, nf);
    check(irq_o == 0, "R9 rearm clears flag", irq_o, 0);

    // R11: disabling cancels the alarm
    arm_at(32'd20, nf);
    alarm_en_i = 1'b0;
    while (ncnt < nf + 8) @(negedge clk);
    check(irq_o == 0, "R11 disabled alarm silent", irq_o, 0);
    alarm_en_i = 1'b1;
    repeat (PER * DIV * 3) @(negedge clk);
    check(irq_o == 0, "R11 reenable does not rearm", irq_o, 0);

    // R11: arm ignored while disabled
    alarm_en_i = 1'b0;
    arm_at(32'd8, nf);
    alarm_en_i = 1'b1;
    while (ncnt < nf + 8) @(negedge clk);
    check(irq_o == 0, "R11 arm ignored when disabled", irq_o, 0);

    // R11: disabling drops a raised flag
    arm_at(32'd12, nf);
    while (ncnt < nf) @(negedge clk);
    check(irq_o == 1, "R11 setup fire", irq_o, 1);
    alarm_en_i = 1'b0;
    @(negedge clk);
    check(irq_o == 0, "R11 disable drops flag", irq_o, 0);
    alarm_en_i = 1'b1;

    // R5: reset in the middle of operation
    rst = 1'b1;
    @(negedge clk);
    check(us_o == 0, "R5 mid-run reset", us_o, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(us_o == us_at((ncnt - 1) / DIV), "R5 restart from zero", us_o,
          us_at((ncnt - 1) / DIV));

    finish_run();
  end

endmodule